// File: doc/BRIEF.md
# Asynchronous Byte-FIFO Bus Master

This block lives in a synchronous FPGA design and runs the host side of an external 8-bit asynchronous FIFO port. The port has the following pins:

- an active-low read strobe;
- a write strobe that commits data when it falls;
- an active-low "receive byte waiting" flag;
- an active-low "transmit room available" flag;
- a shared data bus, split here into in, out and output-enable.

Inside the FPGA the block offers two byte streams with valid/ready handshakes. One stream delivers received bytes. The other accepts bytes to send.

All three asynchronous status inputs pass through a two-flop synchroniser. These are the receive flag, the transmit flag and the link-suspended indication. Every strobe phase is timed by a parameter in clock cycles:

- read-low width;
- write setup;
- write-high width;
- write-hold width;
- post-transfer hold-off.

When both directions are pending at the same time, the block alternates between them. While the link is suspended, a wakeup request makes the block drive the receive-flag pin low for a programmed number of cycles.

Back-pressure rules on the streams:

- Receive side: once `rx_valid_o` rises, it stays high with `rx_data_o` unchanged until `rx_ready_i` is seen high on a clock edge. No new external read starts while a received byte is still waiting.
- Transmit side: `tx_ready_o` does not depend on `tx_valid_i`. A byte is taken on any edge where both are high.

Top module: `afifo_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_n_o` is 1 and all of the following are 0: `wr_o`, `bus_oe_o`, `rxf_drive_o`, `rx_valid_o`.
- R2: A read starts only when the synchronised receive flag is low. `rd_n_o` then stays low for exactly STROBE_LO cycles, and the bus is sampled on the last of those cycles.
- R3: A received byte is held on `rx_valid_o` and `rx_data_o`, both stable, until it is accepted. No further read starts while it is held.
- R4: A write starts only when the synchronised transmit flag is low. While that flag is high, no write starts.
- R5: In a write, the bus is driven for SETUP cycles before `wr_o` rises. `wr_o` stays high for STROBE_HI cycles. When `wr_o` falls, the bus is still driven, and it stays driven for STROBE_LO cycles after the fall.
- R6: `bus_oe_o` is never 1 while `rd_n_o` is 0.
- R7: After each read or write ends, at least HOLDOFF idle cycles pass before the next strobe or bus drive.
- R8: When both a read and a write are possible at each decision point, the two kinds of transfer strictly alternate.
- R9: No read or write starts while the synchronised suspend input is high.
- R10: A `wake_req_i` pulse while suspended drives `rxf_drive_o` high for exactly WAKE_CYCLES cycles. A pulse while not suspended has no effect.
- R11: Bytes leave the receive stream in the order they were read. They are committed on the bus in the order they were accepted on the transmit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxf_n_i | input | 1 | Receive-byte-waiting flag, active low, asynchronous |
| rxf_drive_o | output | 1 | When 1, the receive-flag pin is to be driven low (wakeup) |
| txe_n_i | input | 1 | Transmit-room flag, active low, asynchronous |
| suspend_i | input | 1 | Link suspended indication, high when suspended |
| wake_req_i | input | 1 | Request a wakeup pulse |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_o | output | 1 | Write strobe, commits on falling edge |
| bus_i | input | 8 | Data bus as seen at the pins |
| bus_o | output | 8 | Data to drive on the bus |
| bus_oe_o | output | 1 | Bus output enable |
| rx_valid_o | output | 1 | Received byte valid |
| rx_data_o | output | 8 | Received byte |
| rx_ready_i | input | 1 | Consumer accepts received byte |
| tx_valid_i | input | 1 | Byte to send is valid |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Block accepts byte to send |

## Verification
A new read and a new write can both become eligible on the same cycle when the receive flag is low, the receive slot is empty and a transmit byte is offered. The arbiter then has to pick exactly one of them.

The bench provokes this by loading the external receive model and the transmit source with several bytes each, with both flags ready and the consumer always ready. It then logs the kind of every transfer that starts while both queues still hold at least two bytes, and judges that consecutive starts differ.

On every clock it also checks that a write's bus drive and a read strobe never overlap.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_WR_SETUP,
    ST_WR_HI,
    ST_WR_LO,
    ST_GAP
  } phase_t;
endpackage

// File: rtl/afifo_flag_sync.sv
module afifo_flag_sync #(
  parameter int         W   = 3,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/afifo_wake.sv
module afifo_wake #(
  parameter bit ENABLE      = 1'b1,
  parameter int WAKE_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic susp_i,
  input  logic req_i,
  output logic drive_o
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  generate
    if (ENABLE) begin : g_wake
      logic [WW-1:0] left_q;
      logic          drive_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          left_q  <= '0;
          drive_q <= 1'b0;
        end else if (drive_q) begin
          if (left_q == '0) drive_q <= 1'b0;
          else              left_q  <= left_q - 1'b1;
        end else if (susp_i && req_i) begin
          drive_q <= 1'b1;
          left_q  <= WW'(WAKE_CYCLES - 1);
        end
      end

      assign drive_o = drive_q;

      a_r10_wake_only_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> $past(susp_i));
    end else begin : g_nowake
      logic unused_wake;
      assign unused_wake = &{1'b0, susp_i, req_i, clk, rst_n};
      assign drive_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/afifo_master.sv
module afifo_master
  import afifo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int STROBE_LO   = 3,
  parameter int STROBE_HI   = 2,
  parameter int SETUP       = 2,
  parameter int HOLDOFF     = 3,
  parameter bit WAKE_EN     = 1'b1,
  parameter int WAKE_CYCLES = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxf_n_i,
  output logic          rxf_drive_o,
  input  logic          txe_n_i,
  input  logic          suspend_i,
  input  logic          wake_req_i,
  output logic          rd_n_o,
  output logic          wr_o,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  input  logic          rx_ready_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o
);
  localparam int CSUM = STROBE_LO + STROBE_HI + SETUP + HOLDOFF;
  localparam int CW   = $clog2(CSUM + 1);

  logic [2:0] flags_s;
  logic       rxf_ok, txe_ok, susp_q;

  afifo_flag_sync #(.W(3), .RST(3'b011)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({suspend_i, txe_n_i, rxf_n_i}),
    .sync_o  (flags_s)
  );

  assign rxf_ok = !flags_s[0];
  assign txe_ok = !flags_s[1];
  assign susp_q = flags_s[2];

  afifo_wake #(.ENABLE(WAKE_EN), .WAKE_CYCLES(WAKE_CYCLES)) i_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .susp_i  (susp_q),
    .req_i   (wake_req_i),
    .drive_o (rxf_drive_o)
  );

  phase_t         state_q;
  logic [CW-1:0]  cnt_q;
  logic           last_wr_q;
  logic [DW-1:0]  wdata_q;
  logic           rd_ok, go_rd, go_wr, idle;

  assign idle       = (state_q == ST_IDLE);
  assign rd_ok      = rxf_ok && !rx_valid_o && !susp_q && !rxf_drive_o;
  assign tx_ready_o = idle && txe_ok && !susp_q && !(rd_ok && last_wr_q);
  assign go_wr      = tx_valid_i && tx_ready_o;
  assign go_rd      = idle && rd_ok && !go_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_wr_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_wr) begin
            state_q   <= ST_WR_SETUP;
            cnt_q     <= CW'(SETUP - 1);
            wdata_q   <= tx_data_i;
            last_wr_q <= 1'b1;
          end else if (go_rd) begin
            state_q   <= ST_RD_LO;
            cnt_q     <= CW'(STROBE_LO - 1);
            last_wr_q <= 1'b0;
          end
        end
        ST_RD_LO: begin
          if (cnt_q == '0) begin
            state_q <= ST_GAP;
            cnt_q   <= CW'(HOLDOFF - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WR_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_WR_HI;
            cnt_q   <= CW'(STROBE_HI - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WR_HI: begin
          if (cnt_q == '0) begin
            state_q <= ST_WR_LO;
            cnt_q   <= CW'(STROBE_LO - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WR_LO: begin
          if (cnt_q == '0) begin
            state_q <= ST_GAP;
            cnt_q   <= CW'(HOLDOFF - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_GAP: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // receive holding slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else if (state_q == ST_RD_LO && cnt_q == '0) begin
      rx_valid_o <= 1'b1;
      rx_data_o  <= bus_i;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  assign rd_n_o   = (state_q != ST_RD_LO);
  assign wr_o     = (state_q == ST_WR_HI);
  assign bus_oe_o = (state_q == ST_WR_SETUP) || (state_q == ST_WR_HI) ||
                    (state_q == ST_WR_LO);
  assign bus_o    = wdata_q;

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> rd_n_o);
  a_r2_read_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o) |-> $past(rxf_ok));
  a_r4_write_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(txe_ok));
  a_r5_commit_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> bus_oe_o);
  a_r5_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_o) |-> $past(bus_oe_o));
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));
  a_r9_no_read_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o) |-> !$past(susp_q));
  a_r9_no_write_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> !$past(susp_q));
endmodule

// File: tb/test_afifo_master.sv
module test_afifo_master;
  localparam int LO = 3, HI = 2, SU = 2, HO = 3, WK = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic rxf_n_i, rxf_drive_o, txe_n_i, suspend_i, wake_req_i;
  logic rd_n_o, wr_o, bus_oe_o, rx_valid_o, rx_ready_i, tx_valid_i, tx_ready_o;
  logic [7:0] bus_i, bus_o, rx_data_o, tx_data_i;

  byte ext[$], exp_rx[$], src[$], exp_wr[$];
  logic ext_empty = 1'b1;
  logic [7:0] ext_front = 8'h00;
  logic txe_hi = 1'b0, tx_en = 1'b1;

  assign rxf_n_i = rxf_drive_o ? 1'b0 : ext_empty;
  assign txe_n_i = txe_hi;
  assign bus_i   = rd_n_o ? 8'h00 : ext_front;

  afifo_master #(.STROBE_LO(LO), .STROBE_HI(HI), .SETUP(SU), .HOLDOFF(HO),
                 .WAKE_EN(1'b1), .WAKE_CYCLES(WK)) i_afifo_master (
    .clk(clk), .rst_n(rst_n), .rxf_n_i(rxf_n_i), .rxf_drive_o(rxf_drive_o),
    .txe_n_i(txe_n_i), .suspend_i(suspend_i), .wake_req_i(wake_req_i),
    .rd_n_o(rd_n_o), .wr_o(wr_o), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe_o(bus_oe_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_ready_i(rx_ready_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic upd_ext();
    ext_empty = (ext.size() == 0);
    ext_front = (ext.size() > 0) ? ext[0] : 8'h00;
  endtask

  int rd_lo_cnt = 0, wr_hi_cnt = 0, su_cnt = 0, post_cnt = 0, gap_cnt = 100;
  int empty_run = 0, txe_run = 0, susp_run = 0, drive_run = 0;
  int wakes = 0, reads = 0, writes = 0, last_op = -1;
  bit prev_rd = 1, prev_wr = 0, prev_oe = 0, prev_drive = 0, seen_hi = 0;
  bit rx_hs = 0, tx_hs = 0, prev_rxv = 0, prev_rxr = 0, alt_phase = 0;
  byte rx_hs_d, tx_hs_d, prev_rxd, e;

  task automatic note_op(input int k);
    if (alt_phase && ext.size() >= 2 && src.size() >= 2) begin
      if (last_op >= 0) chk(k != last_op, "R8 alternation", k, 1 - last_op);
      last_op = k;
    end
  endtask

  // cycle-by-cycle reference checking, sampled at the falling edge
  initial begin
    rx_ready_i = 1'b1; tx_valid_i = 1'b0; tx_data_i = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (tx_hs) begin exp_wr.push_back(tx_hs_d); void'(src.pop_front()); end
        if (rx_hs) begin
          e = exp_rx.pop_front();
          chk(rx_hs_d == e, "R11 rx order", rx_hs_d, e);
        end
        if (prev_rxv && !prev_rxr)
          chk(rx_valid_o && rx_data_o == prev_rxd, "R3 hold", rx_data_o, prev_rxd);
        chk(!(bus_oe_o && !rd_n_o), "R6 contention", bus_oe_o, 0);
        if (prev_rd && !rd_n_o) begin
          reads++;
          chk(empty_run < 4, "R2 read on empty flag", empty_run, 0);
          chk(susp_run < 4, "R9 read suspended", susp_run, 0);
          chk(gap_cnt >= HO, "R7 holdoff before read", gap_cnt, HO);
          note_op(0);
        end
        if (!rd_n_o) rd_lo_cnt++;
        if (!prev_rd && rd_n_o) begin
          chk(rd_lo_cnt == LO, "R2 read width", rd_lo_cnt, LO);
          rd_lo_cnt = 0;
          void'(ext.pop_front()); upd_ext();
        end
        if (!prev_oe && bus_oe_o) begin
          writes++;
          chk(txe_run < 4, "R4 write on full flag", txe_run, 0);
          chk(susp_run < 4, "R9 write suspended", susp_run, 0);
          chk(gap_cnt >= HO, "R7 holdoff before write", gap_cnt, HO);
          su_cnt = 0; seen_hi = 0; post_cnt = 0;
          note_op(1);
        end
        if (bus_oe_o && !wr_o && !seen_hi) su_cnt++;
        if (!prev_wr && wr_o) begin
          chk(su_cnt == SU, "R5 setup", su_cnt, SU);
          seen_hi = 1; wr_hi_cnt = 0;
        end
        if (wr_o) wr_hi_cnt++;
        if (prev_wr && !wr_o) begin
          chk(wr_hi_cnt == HI, "R5 high width", wr_hi_cnt, HI);
          chk(bus_oe_o, "R5 driven at commit", bus_oe_o, 1);
          e = (exp_wr.size() > 0) ? exp_wr.pop_front() : 8'hxx;
          chk(bus_o == e, "R11 tx order", bus_o, e);
        end
        if (bus_oe_o && seen_hi && !wr_o) post_cnt++;
        if (prev_oe && !bus_oe_o) chk(post_cnt == LO, "R5 hold width", post_cnt, LO);
        if ((!prev_rd && rd_n_o) || (prev_oe && !bus_oe_o)) gap_cnt = 0;
        else if (rd_n_o && !bus_oe_o) gap_cnt++;
        if (rxf_drive_o) drive_run++;
        if (prev_drive && !rxf_drive_o) begin
          chk(drive_run == WK, "R10 wake length", drive_run, WK);
          wakes++; drive_run = 0;
        end
        empty_run = rxf_n_i ? empty_run + 1 : 0;
        txe_run   = txe_n_i ? txe_run + 1 : 0;
        susp_run  = suspend_i ? susp_run + 1 : 0;
        prev_rd = rd_n_o; prev_wr = wr_o; prev_oe = bus_oe_o; prev_drive = rxf_drive_o;
      end
      tx_valid_i = tx_en && (src.size() > 0);
      tx_data_i  = (src.size() > 0) ? src[0] : 8'h00;
      #1;
      rx_hs = rst_n && rx_valid_o && rx_ready_i;  rx_hs_d = rx_data_o;
      tx_hs = rst_n && tx_valid_i && tx_ready_o;  tx_hs_d = tx_data_i;
      prev_rxv = rx_valid_o; prev_rxr = rx_ready_i; prev_rxd = rx_data_o;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000; i++) begin
      if (ext.size() == 0 && exp_rx.size() == 0 && src.size() == 0 &&
          exp_wr.size() == 0 && rx_valid_o == 0 && rd_n_o && !bus_oe_o) break;
      cyc(1);
    end
    chk(exp_rx.size() == 0 && exp_wr.size() == 0 && src.size() == 0,
        "R11 drained", exp_rx.size() + exp_wr.size() + src.size(), 0);
  endtask

  task automatic push_rx(input byte b);
    ext.push_back(b); exp_rx.push_back(b); upd_ext();
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int r0, w0, k0;
  initial begin
    suspend_i = 1'b0; wake_req_i = 1'b0;
    cyc(5);
    chk(rd_n_o && !wr_o && !bus_oe_o && !rxf_drive_o && !rx_valid_o, "R1 in reset",
        {rd_n_o, wr_o, bus_oe_o, rxf_drive_o, rx_valid_o}, 5'b10000);
    rst_n = 1'b1;
    cyc(1);
    chk(rd_n_o && !wr_o && !bus_oe_o && !rxf_drive_o && !rx_valid_o, "R1 after reset",
        {rd_n_o, wr_o, bus_oe_o, rxf_drive_o, rx_valid_o}, 5'b10000);
    // R2 plain reads
    for (int i = 0; i < 5; i++) push_rx(byte'(8'h10 + i));
    drain();
    // R3 back-pressure
    rx_ready_i = 1'b0;
    r0 = reads;
    for (int i = 0; i < 3; i++) push_rx(byte'(8'hA0 + i));
    cyc(40);
    chk(reads - r0 == 1, "R3 single read while held", reads - r0, 1);
    rx_ready_i = 1'b1;
    drain();
    // R5 writes
    for (int i = 0; i < 4; i++) src.push_back(byte'(8'h50 + i));
    drain();
    // R4 transmit flag blocks
    txe_hi = 1'b1;
    cyc(4);
    w0 = writes;
    src.push_back(8'hC3); src.push_back(8'h3C);
    cyc(30);
    chk(writes == w0, "R4 blocked", writes - w0, 0);
    txe_hi = 1'b0;
    drain();
    // R8 both pending
    alt_phase = 1;
    for (int i = 0; i < 8; i++) begin push_rx(byte'(8'h80 + i)); src.push_back(byte'(8'hE0 + i)); end
    drain();
    alt_phase = 0;
    chk(last_op >= 0, "R8 exercised", last_op, 0);
    // R9 suspend blocks, R10 wake
    suspend_i = 1'b1;
    cyc(4);
    r0 = reads; w0 = writes;
    push_rx(8'h99); src.push_back(8'h66);
    cyc(30);
    chk(reads == r0 && writes == w0, "R9 idle while suspended", reads + writes - r0 - w0, 0);
    k0 = wakes;
    wake_req_i = 1'b1; cyc(1); wake_req_i = 1'b0;
    cyc(WK + 10);
    chk(wakes == k0 + 1, "R10 wake issued", wakes - k0, 1);
    suspend_i = 1'b0;
    drain();
    cyc(4);
    k0 = wakes;
    wake_req_i = 1'b1; cyc(1); wake_req_i = 1'b0;
    cyc(10);
    chk(wakes == k0 && !rxf_drive_o && drive_run == 0, "R10 ignored awake", drive_run, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule